// File: doc/BRIEF.md
# Paged Memory Window Mapper

This block widens a 16-bit processor address space to a 24-bit physical space. The processor space is cut into sixteen 4 KiB windows, and the top four address bits pick one of them. Each window owns a page register. When mapping is on, the chosen register's page number replaces the window number in front of the 12-bit offset. When mapping is off, every window passes through to the page that carries its own number.

Software reaches the page registers as 16-bit words in a small register window at 0x4000. This works only while the register-access control bit is set. Page numbers cross the data bus byte-swapped. The low eight page bits ride in the upper data byte, and the page's top nibble rides in the lower data byte. A strap input selects the page width. Narrow mode uses 8-bit pages, which gives 256 pages. Wide mode uses 12-bit pages, which gives 4096 pages. A two-bit control register, written through its own strobe, holds the access and map enables. Turning mapping off never disturbs the stored registers, so turning it back on restores the earlier map.

Top module: `page_window_mapper`

## Requirements
- R1: After reset, page register i holds i (i = 0..15), and both control bits are clear.
- R2: Register i is the 16-bit word at byte address 0x4000 + 2*i. Odd addresses and addresses outside 0x4000..0x401F neither write nor read any register.
- R3: With control bit 1 set, physAddr = {page, cpuAddr[11:0]}, where page is the register selected by cpuAddr[15:12].
- R4: A register write in wide mode stores page[7:0] = wrData[15:8] and page[11:8] = wrData[3:0]. wrData[7:4] is ignored, so 0x4503 and 0x45F3 both store page 0x345.
- R5: In narrow mode (cfgWide = 0), wrData[7:0] is ignored on writes, and physAddr[23:20] is forced to zero.
- R6: While control bit 0 is clear, register writes have no effect and rdData reads 0.
- R7: With control bit 1 clear, physAddr = {8'h00, cpuAddr}, whatever the registers hold.
- R8: Clearing and then setting control bit 1 restores the mapping held before, because the registers are unchanged.
- R9: A register read returns rdData = {page[7:0], 4'h0, page[11:8]} in the same cycle. In narrow mode the low byte reads 0.
- R10: A pulse on ctrlWr loads ctrlData[1:0] into the control register (bit 0 = register access, bit 1 = map enable), effective from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWide | input | 1 | Page width strap: 1 = 12-bit pages, 0 = 8-bit pages |
| ctrlWr | input | 1 | Control register load strobe |
| ctrlData | input | 2 | Control bits: [0] register access, [1] map enable |
| busAddr | input | 16 | Register-window byte address |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| wrData | input | 16 | Byte-swapped page number to write |
| rdData | output | 16 | Byte-swapped page number read back, 0 when not reading |
| cpuAddr | input | 16 | Processor address to translate |
| physAddr | output | 24 | Translated physical address |

## Verification
Some properties are checked by the assertions on every cycle: pass-through while mapping is off, a zero top nibble in narrow mode, a zero read bus while register access is locked, and registers that stay put in every cycle without a write strobe. Only the bench scenarios can show that the byte-swapped encoding lands in the right register and window, that the top data nibble is masked, and that a map-off and map-on sequence brings back the earlier translation.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int NUM_WIN  = 16;
  localparam int WIN_W    = $clog2(NUM_WIN);
  localparam int OFF_W    = 12;
  localparam int PAGE_W   = 12;
  localparam int NARROW_W = 8;
  localparam int CPU_W    = WIN_W + OFF_W;
  localparam int PHYS_W   = PAGE_W + OFF_W;
  localparam int DATA_W   = 16;
  localparam logic [CPU_W-1:0] REG_BASE = 16'h4000;

  typedef struct packed {
    logic             regWr;
    logic             regRd;
    logic [WIN_W-1:0] regIdx;
    logic             accessEn;
    logic             mapEn;
  } mapStrobe_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic [1:0]       ctrlData,
  input  logic [CPU_W-1:0] busAddr,
  input  logic             busWr,
  input  logic             busRd,
  output mapStrobe_t       strb
);
  localparam int IDX_LO = 1;
  localparam int HIT_LO = IDX_LO + WIN_W;

  logic accessQ, mapQ;
  logic winHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accessQ <= 1'b0;
      mapQ    <= 1'b0;
    end else if (ctrlWr) begin
      accessQ <= ctrlData[0];
      mapQ    <= ctrlData[1];
    end
  end

  assign winHit = (busAddr[CPU_W-1:HIT_LO] == REG_BASE[CPU_W-1:HIT_LO]) && !busAddr[0];

  always_comb begin
    strb.accessEn = accessQ;
    strb.mapEn    = mapQ;
    strb.regIdx   = busAddr[HIT_LO-1:IDX_LO];
    strb.regWr    = busWr && winHit && accessQ;
    strb.regRd    = busRd && winHit && accessQ;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(strb.mapEn) && $stable(strb.accessEn)) else $error("control bits moved"); // R10
endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWide,
  input  mapStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CPU_W-1:0]  cpuAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [PHYS_W-1:0] physAddr
);
  localparam int HI_W = PAGE_W - NARROW_W;

  logic [NUM_WIN-1:0][PAGE_W-1:0] pageRegs;
  logic [PAGE_W-1:0] wrPage;
  logic [PAGE_W-1:0] rdPage;
  logic [PAGE_W-1:0] xlPage;
  logic [WIN_W-1:0]  cpuWin;

  always_comb begin
    wrPage[NARROW_W-1:0]      = wrData[DATA_W-1:DATA_W-NARROW_W];
    wrPage[PAGE_W-1:NARROW_W] = cfgWide ? wrData[HI_W-1:0] : '0;
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rstN)
        pageRegs[gi] <= PAGE_W'(gi);
      else if (strb.regWr && strb.regIdx == WIN_W'(gi))
        pageRegs[gi] <= wrPage;
    end
  end

  assign rdPage = pageRegs[strb.regIdx];

  always_comb begin
    rdData = '0;
    if (strb.regRd) begin
      rdData[DATA_W-1:DATA_W-NARROW_W] = rdPage[NARROW_W-1:0];
      if (cfgWide) rdData[HI_W-1:0] = rdPage[PAGE_W-1:NARROW_W];
    end
  end

  assign cpuWin = cpuAddr[CPU_W-1:OFF_W];

  always_comb begin
    if (strb.mapEn) xlPage = pageRegs[cpuWin];
    else            xlPage = PAGE_W'(cpuWin);
    if (!cfgWide) xlPage[PAGE_W-1:NARROW_W] = '0;
  end

  assign physAddr = {xlPage, cpuAddr[OFF_W-1:0]};

  AST_REGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regWr |=> $stable(pageRegs)) else $error("register moved without write"); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.regWr |=> pageRegs[$past(strb.regIdx)][NARROW_W-1:0] == $past(wrData[DATA_W-1:DATA_W-NARROW_W]))
    else $error("write lost"); // R4
  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWide |-> physAddr[PHYS_W-1:PHYS_W-HI_W] == '0) else $error("narrow top nibble set"); // R5
endmodule

// File: rtl/page_window_mapper.sv
module page_window_mapper
  import mapper_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWide,
  input  logic        ctrlWr,
  input  logic [1:0]  ctrlData,
  input  logic [15:0] busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic [15:0] cpuAddr,
  output logic [23:0] physAddr
);
  mapStrobe_t strb;

  mapper_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWr   (ctrlWr),
    .ctrlData (ctrlData),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .strb     (strb)
  );

  mapper_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWide  (cfgWide),
    .strb     (strb),
    .wrData   (wrData),
    .cpuAddr  (cpuAddr),
    .rdData   (rdData),
    .physAddr (physAddr)
  );

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !strb.mapEn |-> physAddr == {8'h00, cpuAddr}) else $error("pass-through broken"); // R7
  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accessEn |-> rdData == 16'h0000) else $error("read while locked"); // R6
endmodule

// File: tb/test_page_window_mapper.sv
module test_page_window_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWide = 1'b1;
  logic        ctrlWr = 1'b0;
  logic [1:0]  ctrlData = 2'b00;
  logic [15:0] busAddr = 16'h0000;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] wrData = 16'h0000;
  logic [15:0] rdData;
  logic [15:0] cpuAddr = 16'h0000;
  logic [23:0] physAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  page_window_mapper i_page_window_mapper (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .wrData(wrData), .rdData(rdData),
    .cpuAddr(cpuAddr), .physAddr(physAddr)
  );

  // {wide, window, wrData, expected rdData, expected physAddr at offset 0xABC}
  localparam logic [60:0] VEC [6] = '{
    {1'b1, 4'h3, 16'h4503, 16'h4503, 24'h345ABC},
    {1'b1, 4'h5, 16'h45F3, 16'h4503, 24'h345ABC},
    {1'b0, 4'hA, 16'hFF0C, 16'hFF00, 24'h0FFABC},
    {1'b1, 4'hF, 16'h000F, 16'h000F, 24'hF00ABC},
    {1'b0, 4'h0, 16'h1234, 16'h1200, 24'h012ABC},
    {1'b1, 4'h7, 16'hFFFF, 16'hFF0F, 24'hFFFABC}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setCtrl(input logic [1:0] v);
    @(negedge clk); ctrlWr = 1'b1; ctrlData = v;
    @(negedge clk); ctrlWr = 1'b0;
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); busAddr = a; wrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic regRead(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 d = rdData;
    busRd = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R7: reset pass-through, access locked
    cpuAddr = 16'h3123; #1 chk("R1", physAddr, 24'h003123);
    regRead(16'h4006, rd); chk("R6", {8'h0, rd}, 24'h0);

    // R10: access on, map on; R1 registers hold own index
    setCtrl(2'b11);
    regRead(16'h4006, rd); chk("R9", {8'h0, rd}, 24'h000300);
    cpuAddr = 16'hA123; #1 chk("R1", physAddr, 24'h00A123);

    // Vector loop: R3 R4 R5 R9
    for (int i = 0; i < 6; i++) begin
      cfgWide = VEC[i][60];
      regWrite(16'h4000 + 16'(VEC[i][59:56]) * 2, VEC[i][55:40]);
      regRead(16'h4000 + 16'(VEC[i][59:56]) * 2, rd);
      chk("R4/R9", {8'h0, rd}, {8'h0, VEC[i][39:24]});
      cpuAddr = {VEC[i][59:56], 12'hABC}; #1
      chk("R3/R5", physAddr, VEC[i][23:0]);
    end
    cfgWide = 1'b1;

    // R6: write ignored while locked
    setCtrl(2'b10);
    regWrite(16'h4004, 16'h7700);
    regRead(16'h4004, rd); chk("R6", {8'h0, rd}, 24'h0);
    setCtrl(2'b11);
    regRead(16'h4004, rd); chk("R6", {8'h0, rd}, 24'h000200);

    // R2: out-of-window and odd addresses ignored
    regWrite(16'h4020, 16'h5500);
    regWrite(16'h4003, 16'h6600);
    regRead(16'h4002, rd); chk("R2", {8'h0, rd}, 24'h000100);
    regRead(16'h4000, rd); chk("R2", {8'h0, rd}, 24'h001200);

    // R7 / R8: map off then back on
    setCtrl(2'b01);
    cpuAddr = 16'h3ABC; #1 chk("R7", physAddr, 24'h003ABC);
    setCtrl(2'b11);
    cpuAddr = 16'h3ABC; #1 chk("R8", physAddr, 24'h345ABC);

    // R5: narrow mode masks stored top nibble at output
    cfgWide = 1'b0;
    cpuAddr = 16'hFABC; #1 chk("R5", physAddr, 24'h000ABC);
    regRead(16'h401E, rd); chk("R5", {8'h0, rd}, 24'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule